// File: doc/BRIEF.md
# Transfer Descriptor Status Update Unit

This unit sits between the descriptor fetch logic and the writeback logic of a USB host controller's schedule engine. For each completed bus transaction it takes the descriptor's 32-bit control word, the descriptor's 32-bit token word and the outcome reported by the bus side: a received byte count plus a result code. It returns the control word that should be written back, together with the decisions the list walker needs. These decisions say whether the queue element pointer moves on, whether the frame must stop, and whether a completion interrupt, a USB error or a process error is raised.

The token is decoded into packet identifier, device address, endpoint, data toggle and maximum length. The result is then applied. A success records the actual length and retires the descriptor. A NAK leaves it live. A stall retires it. A timeout counts down the retry budget. A babble retires it and stops the frame. A `changed` flag tells the writeback path whether the control word must be stored at all. There is one transaction per valid cycle, and every output is registered one cycle after the input.

Top module: `td_status_updater`

## Requirements
- R1: While `rst` is high and in every cycle after a cycle with `in_valid` low, `out_valid`, `advance`, `irq_req`, `usb_err`, `proc_err`, `frame_stop`, `short_pkt`, `changed` and `skipped` are 0.
- R2: The token word is decoded as follows. Bits 7:0 are the packet identifier. Bits 14:8 are the device address (`dev_addr`). Bits 18:15 are the endpoint (`endpoint`). Bit 19 is the data toggle (`data_toggle`). The maximum length is (bits 31:21 + 1) modulo 2048, so a field of 0x7FF means zero bytes.
- R3: A control word with bit 23 (active) clear produces `skipped`=1 and leaves the control word unchanged. It also gives `advance`=0, `usb_err`=0, `proc_err`=0 and `frame_stop`=0.
- R4: `irq_req` equals control bit 24 (interrupt on complete) of the input word for every valid transaction, whatever the outcome.
- R5: A success (result code 0) with a count no larger than the maximum length does three things to an active descriptor with a valid token. It writes (count − 1) mod 2048 into control bits 10:0, clears bit 23 (active) and bit 19 (NAK), and sets `advance`=1, except in the case of R7.
- R6: A success whose count is larger than the maximum length is handled exactly like a babble result (R11).
- R7: On a success, `short_pkt`=1 and `advance`=0 when three conditions hold: the packet identifier is IN (0x69), control bit 29 (short-packet detect) is set, and the count is below the maximum length.
- R8: A timeout (code 3) sets control bit 18. If the error counter in bits 28:27 is non-zero, it is decremented. If the decrement reaches zero, bit 23 is cleared and `usb_err`=1. A counter already at zero is left alone and the descriptor stays active.
- R9: A NAK (code 1) sets control bit 19 and keeps bit 23 set, with `advance`=0.
- R10: A stall (code 2, and any unused code 5 to 7) sets control bit 22 and clears bit 23, with `advance`=0 and `frame_stop`=0.
- R11: A babble (code 4) sets control bits 20 and 22, clears bit 23, and gives `frame_stop`=1 and `advance`=0. Control bits 10:0 are unchanged.
- R12: A token on an active descriptor is invalid in two cases: the packet identifier is not SETUP (0x2D), IN (0x69) or OUT (0xE1), or token bit 20 (reserved) is set. An invalid token gives `proc_err`=1 and `frame_stop`=1 and leaves the control word unchanged.
- R13: `changed` is 1 exactly when `ctrl_out` differs from the `ctrl_in` of the same transaction.
- R14: `out_valid` follows `in_valid` with a latency of one clock, and all outputs of a transaction appear in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Transaction present this cycle |
| ctrl_in | input | 32 | Descriptor control word as fetched |
| token_in | input | 32 | Descriptor token word |
| result_in | input | 3 | Outcome code: 0 ok, 1 NAK, 2 stall, 3 timeout, 4 babble |
| rx_count | input | CNT_W (12) | Bytes moved by the transaction |
| out_valid | output | 1 | Outputs below belong to a transaction |
| ctrl_out | output | 32 | Control word to write back |
| dev_addr | output | 7 | Decoded device address |
| endpoint | output | 4 | Decoded endpoint number |
| data_toggle | output | 1 | Decoded data toggle |
| advance | output | 1 | Move the queue element pointer to the next descriptor |
| irq_req | output | 1 | Completion interrupt request |
| usb_err | output | 1 | Retry budget exhausted |
| proc_err | output | 1 | Invalid token, process error |
| frame_stop | output | 1 | Abandon the rest of this frame |
| short_pkt | output | 1 | Short packet detected on IN |
| changed | output | 1 | Writeback needed |
| skipped | output | 1 | Descriptor was inactive |

## Verification
The assertions assume that `rst` is held for at least one clock before the first transaction. They also assume that `result_in` and `rx_count` carry meaningful values only when `in_valid` is high, and that nothing downstream holds the outputs back. The stimulus keeps within this: it drives all inputs half a cycle away from the sampling edge and keeps `in_valid` low during reset. It mixes directed corner cases with random ones: zero-length maxima, counts one above, equal to and below the maximum, error counters at each value, inactive descriptors and bad packet identifiers. Random counts cluster around the decoded maximum so that the babble and short-packet boundaries are hit often.

// File: rtl/td_upd_pkg.sv
package td_upd_pkg;

  // control word bit positions
  localparam int unsigned CB_TMO   = 18;
  localparam int unsigned CB_NAK   = 19;
  localparam int unsigned CB_BAB   = 20;
  localparam int unsigned CB_STL   = 22;
  localparam int unsigned CB_ACT   = 23;
  localparam int unsigned CB_IOC   = 24;
  localparam int unsigned CB_ERRLO = 27;
  localparam int unsigned CB_SPD   = 29;
  localparam int unsigned ERR_W    = 2;

  // token field geometry
  localparam int unsigned TK_PID_W  = 8;
  localparam int unsigned TK_ADDR_LO = 8;
  localparam int unsigned TK_ADDR_W = 7;
  localparam int unsigned TK_EP_LO  = 15;
  localparam int unsigned TK_EP_W   = 4;
  localparam int unsigned TK_TGL    = 19;
  localparam int unsigned TK_RSV    = 20;
  localparam int unsigned TK_LEN_LO = 21;

  localparam logic [7:0] PID_SETUP = 8'h2D;
  localparam logic [7:0] PID_IN    = 8'h69;
  localparam logic [7:0] PID_OUT   = 8'hE1;

  typedef enum logic [2:0] {
    RES_OK     = 3'd0,
    RES_NAK    = 3'd1,
    RES_STALL  = 3'd2,
    RES_TMO    = 3'd3,
    RES_BABBLE = 3'd4
  } res_e;

  typedef struct packed {
    logic [31:0] ctrl;
    logic        advance;
    logic        irq;
    logic        usb_err;
    logic        proc_err;
    logic        frame_stop;
    logic        short_pkt;
    logic        changed;
    logic        skipped;
  } upd_s;

endpackage

// File: rtl/td_tok_decode.sv
module td_tok_decode
  import td_upd_pkg::*;
#(
  parameter int unsigned LEN_W = 11
) (
  input  logic [31:0]          token,
  output logic [6:0]           addr,
  output logic [3:0]           ep,
  output logic                 toggle,
  output logic [LEN_W-1:0]     max_len,
  output logic                 tok_ok,
  output logic                 is_in
);
  localparam int unsigned LEN_HI = TK_LEN_LO + LEN_W - 1;

  logic [TK_PID_W-1:0] pid;
  logic                pid_known;

  assign pid     = token[TK_PID_W-1:0];
  assign addr    = token[TK_ADDR_LO +: TK_ADDR_W];
  assign ep      = token[TK_EP_LO +: TK_EP_W];
  assign toggle  = token[TK_TGL];
  // wraps: an all-ones field encodes a zero-byte packet
  assign max_len = token[LEN_HI:TK_LEN_LO] + LEN_W'(1);

  always_comb begin
    unique case (pid)
      PID_SETUP, PID_IN, PID_OUT: pid_known = 1'b1;
      default:                    pid_known = 1'b0;
    endcase
  end

  assign tok_ok = pid_known && !token[TK_RSV];
  assign is_in  = (pid == PID_IN);

endmodule

// File: rtl/td_status_rules.sv
module td_status_rules
  import td_upd_pkg::*;
#(
  parameter int unsigned LEN_W = 11,
  parameter int unsigned CNT_W = 12
) (
  input  logic [31:0]      ctrl_in,
  input  logic [2:0]       result,
  input  logic [CNT_W-1:0] count,
  input  logic [LEN_W-1:0] max_len,
  input  logic             tok_ok,
  input  logic             is_in,
  output upd_s             upd
);
  logic [CNT_W-1:0] max_ext;
  logic [LEN_W-1:0] act_len;
  logic             overlong;
  logic             undersize;
  logic [ERR_W-1:0] err_cnt;
  logic             do_babble;
  logic [31:0]      nxt;
  res_e             res;

  assign max_ext   = CNT_W'(max_len);
  assign overlong  = count > max_ext;
  assign undersize = count < max_ext;
  assign act_len   = LEN_W'(count - CNT_W'(1));
  assign err_cnt   = ctrl_in[CB_ERRLO +: ERR_W];
  assign res       = res_e'(result);

  always_comb begin
    nxt            = ctrl_in;
    do_babble      = 1'b0;
    upd.advance    = 1'b0;
    upd.irq        = ctrl_in[CB_IOC];
    upd.usb_err    = 1'b0;
    upd.proc_err   = 1'b0;
    upd.frame_stop = 1'b0;
    upd.short_pkt  = 1'b0;
    upd.skipped    = 1'b0;
    if (!ctrl_in[CB_ACT]) begin
      upd.skipped = 1'b1;
    end else if (!tok_ok) begin
      upd.proc_err   = 1'b1;
      upd.frame_stop = 1'b1;
    end else begin
      case (res)
        RES_OK: begin
          if (overlong) begin
            do_babble = 1'b1;
          end else begin
            nxt[LEN_W-1:0] = act_len;
            nxt[CB_ACT]    = 1'b0;
            nxt[CB_NAK]    = 1'b0;
            if (is_in && ctrl_in[CB_SPD] && undersize)
              upd.short_pkt = 1'b1;
            else
              upd.advance = 1'b1;
          end
        end
        RES_NAK: nxt[CB_NAK] = 1'b1;
        RES_TMO: begin
          nxt[CB_TMO] = 1'b1;
          if (err_cnt != '0) begin
            nxt[CB_ERRLO +: ERR_W] = err_cnt - ERR_W'(1);
            if (err_cnt == ERR_W'(1)) begin
              nxt[CB_ACT] = 1'b0;
              upd.usb_err = 1'b1;
            end
          end
        end
        RES_BABBLE: do_babble = 1'b1;
        default: begin
          nxt[CB_STL] = 1'b1;
          nxt[CB_ACT] = 1'b0;
        end
      endcase
      if (do_babble) begin
        nxt[CB_BAB]    = 1'b1;
        nxt[CB_STL]    = 1'b1;
        nxt[CB_ACT]    = 1'b0;
        upd.frame_stop = 1'b1;
      end
    end
    upd.ctrl    = nxt;
    upd.changed = (nxt != ctrl_in);
  end

endmodule

// File: rtl/td_out_stage.sv
module td_out_stage
  import td_upd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  upd_s       upd_d,
  input  logic [6:0] addr_d,
  input  logic [3:0] ep_d,
  input  logic       tgl_d,
  output logic       valid_q,
  output upd_s       upd_q,
  output logic [6:0] addr_q,
  output logic [3:0] ep_q,
  output logic       tgl_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      upd_q   <= '0;
      addr_q  <= '0;
      ep_q    <= '0;
      tgl_q   <= 1'b0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        upd_q  <= upd_d;
        addr_q <= addr_d;
        ep_q   <= ep_d;
        tgl_q  <= tgl_d;
      end else begin
        // hold the word, drop every decision flag
        upd_q.advance    <= 1'b0;
        upd_q.irq        <= 1'b0;
        upd_q.usb_err    <= 1'b0;
        upd_q.proc_err   <= 1'b0;
        upd_q.frame_stop <= 1'b0;
        upd_q.short_pkt  <= 1'b0;
        upd_q.changed    <= 1'b0;
        upd_q.skipped    <= 1'b0;
      end
    end
  end

  // R1
  idle_flags_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_q |-> !(upd_q.advance || upd_q.irq || upd_q.usb_err || upd_q.proc_err ||
                   upd_q.frame_stop || upd_q.short_pkt || upd_q.changed || upd_q.skipped));

endmodule

// File: rtl/td_status_updater.sv
module td_status_updater
  import td_upd_pkg::*;
#(
  parameter int unsigned LEN_W = 11,
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [31:0]      ctrl_in,
  input  logic [31:0]      token_in,
  input  logic [2:0]       result_in,
  input  logic [CNT_W-1:0] rx_count,
  output logic             out_valid,
  output logic [31:0]      ctrl_out,
  output logic [6:0]       dev_addr,
  output logic [3:0]       endpoint,
  output logic             data_toggle,
  output logic             advance,
  output logic             irq_req,
  output logic             usb_err,
  output logic             proc_err,
  output logic             frame_stop,
  output logic             short_pkt,
  output logic             changed,
  output logic             skipped
);
  logic [6:0]       dec_addr;
  logic [3:0]       dec_ep;
  logic             dec_tgl;
  logic [LEN_W-1:0] dec_max;
  logic             dec_ok;
  logic             dec_in;
  upd_s             upd_d;
  upd_s             upd_q;

  td_tok_decode #(.LEN_W(LEN_W)) u_dec (
    .token   (token_in),
    .addr    (dec_addr),
    .ep      (dec_ep),
    .toggle  (dec_tgl),
    .max_len (dec_max),
    .tok_ok  (dec_ok),
    .is_in   (dec_in)
  );

  td_status_rules #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_rules (
    .ctrl_in (ctrl_in),
    .result  (result_in),
    .count   (rx_count),
    .max_len (dec_max),
    .tok_ok  (dec_ok),
    .is_in   (dec_in),
    .upd     (upd_d)
  );

  td_out_stage u_out (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .upd_d    (upd_d),
    .addr_d   (dec_addr),
    .ep_d     (dec_ep),
    .tgl_d    (dec_tgl),
    .valid_q  (out_valid),
    .upd_q    (upd_q),
    .addr_q   (dev_addr),
    .ep_q     (endpoint),
    .tgl_q    (data_toggle)
  );

  assign ctrl_out   = upd_q.ctrl;
  assign advance    = upd_q.advance;
  assign irq_req    = upd_q.irq;
  assign usb_err    = upd_q.usb_err;
  assign proc_err   = upd_q.proc_err;
  assign frame_stop = upd_q.frame_stop;
  assign short_pkt  = upd_q.short_pkt;
  assign changed    = upd_q.changed;
  assign skipped    = upd_q.skipped;

  // R14
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid)) |-> out_valid);

  // R3
  skip_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && skipped) |-> (!changed && !advance && !frame_stop && !usb_err));

  // R5
  advance_retired_chk: assert property (@(posedge clk) disable iff (rst)
    advance |-> (!ctrl_out[CB_ACT] && !ctrl_out[CB_NAK] && !frame_stop));

  // R7
  short_holds_chk: assert property (@(posedge clk) disable iff (rst)
    short_pkt |-> (!advance && !ctrl_out[CB_ACT]));

  // R8
  usb_err_chk: assert property (@(posedge clk) disable iff (rst)
    usb_err |-> (ctrl_out[CB_TMO] && !ctrl_out[CB_ACT] && ctrl_out[CB_ERRLO +: ERR_W] == '0));

  // R11
  babble_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_stop && !proc_err) |-> (ctrl_out[CB_BAB] && ctrl_out[CB_STL] && !ctrl_out[CB_ACT] && !advance));

  // R12
  proc_err_chk: assert property (@(posedge clk) disable iff (rst)
    proc_err |-> (frame_stop && !changed && !advance));

  // R13
  unchanged_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !changed) |-> (skipped || proc_err || ctrl_out[CB_ACT]));

endmodule

// File: tb/tb_td_status_updater.sv
module tb_td_status_updater;
  localparam int CNT_W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [31:0] ctrl_in = '0, token_in = '0;
  logic [2:0] result_in = '0;
  logic [CNT_W-1:0] rx_count = '0;
  logic out_valid, data_toggle, advance, irq_req, usb_err, proc_err;
  logic frame_stop, short_pkt, changed, skipped;
  logic [31:0] ctrl_out;
  logic [6:0] dev_addr;
  logic [3:0] endpoint;

  always #5 clk = ~clk;

  td_status_updater dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .ctrl_in(ctrl_in),
    .token_in(token_in), .result_in(result_in), .rx_count(rx_count),
    .out_valid(out_valid), .ctrl_out(ctrl_out), .dev_addr(dev_addr),
    .endpoint(endpoint), .data_toggle(data_toggle), .advance(advance),
    .irq_req(irq_req), .usb_err(usb_err), .proc_err(proc_err),
    .frame_stop(frame_stop), .short_pkt(short_pkt), .changed(changed),
    .skipped(skipped));

  int checks = 0, failures = 0;
  bit done = 0;

  // expected values for the transaction in flight
  bit e_valid = 0;
  logic [31:0] e_ctrl;
  int e_addr, e_ep, e_tgl;
  bit e_adv, e_irq, e_uerr, e_perr, e_stop, e_short, e_chg, e_skip;
  string e_tag = "R1";

  task automatic chk(input string tag, input string what, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
    end
  endtask

  function automatic void model(input logic [31:0] c, input logic [31:0] t,
                                input int res, input int n);
    int pid, maxl, errc;
    bit ok, babble;
    pid  = int'(t & 32'hFF);
    maxl = (int'(t >> 21) + 1) % 2048;
    ok   = (pid == 'h2D || pid == 'h69 || pid == 'hE1) && !t[20];
    e_addr = int'((t >> 8) & 32'h7F);
    e_ep   = int'((t >> 15) & 32'hF);
    e_tgl  = int'((t >> 19) & 32'h1);
    e_ctrl = c; e_adv = 0; e_uerr = 0; e_perr = 0; e_stop = 0;
    e_short = 0; e_skip = 0; babble = 0;
    e_irq = c[24];
    if (!c[23]) begin e_skip = 1; e_tag = "R3"; end
    else if (!ok) begin e_perr = 1; e_stop = 1; e_tag = "R12"; end
    else if (res == 0 && n > maxl) begin babble = 1; e_tag = "R6"; end
    else if (res == 0) begin
      e_ctrl = (c & ~32'h7FF) | 32'((n + 2047) % 2048);
      e_ctrl[23] = 0; e_ctrl[19] = 0;
      if (pid == 'h69 && c[29] && n < maxl) begin e_short = 1; e_tag = "R7"; end
      else begin e_adv = 1; e_tag = "R5"; end
    end
    else if (res == 1) begin e_ctrl[19] = 1; e_tag = "R9"; end
    else if (res == 3) begin
      e_tag = "R8";
      e_ctrl[18] = 1;
      errc = int'((c >> 27) & 32'h3);
      if (errc > 0) begin
        errc--;
        e_ctrl[28:27] = 2'(errc);
        if (errc == 0) begin e_ctrl[23] = 0; e_uerr = 1; end
      end
    end
    else if (res == 4) begin babble = 1; e_tag = "R11"; end
    else begin e_ctrl[22] = 1; e_ctrl[23] = 0; e_tag = "R10"; end
    if (babble) begin
      e_ctrl[20] = 1; e_ctrl[22] = 1; e_ctrl[23] = 0; e_stop = 1;
    end
    e_chg = (e_ctrl != c);
  endfunction

  task automatic compare();
    chk("R14", "out_valid", out_valid, e_valid);
    if (e_valid) begin
      chk(e_tag, "ctrl_out", ctrl_out, e_ctrl);
      chk("R2", "dev_addr", dev_addr, e_addr);
      chk("R2", "endpoint", endpoint, e_ep);
      chk("R2", "data_toggle", data_toggle, e_tgl);
      chk("R4", "irq_req", irq_req, e_irq);
      chk(e_tag, "advance", advance, e_adv);
      chk(e_tag, "usb_err", usb_err, e_uerr);
      chk(e_tag, "proc_err", proc_err, e_perr);
      chk(e_tag, "frame_stop", frame_stop, e_stop);
      chk(e_tag, "short_pkt", short_pkt, e_short);
      chk("R13", "changed", changed, e_chg);
      chk(e_tag, "skipped", skipped, e_skip);
    end else begin
      chk("R1", "idle flags",
          {advance, irq_req, usb_err, proc_err, frame_stop, short_pkt, changed, skipped}, 0);
    end
  endtask

  // one cycle: check the previous transaction, then present the next
  task automatic step(input bit v, input logic [31:0] c, input logic [31:0] t,
                      input int res, input int n);
    @(negedge clk);
    compare();
    in_valid = v; ctrl_in = c; token_in = t;
    result_in = 3'(res); rx_count = CNT_W'(n);
    e_valid = v && !rst;
    if (e_valid) model(c, t, res, n);
  endtask

  function automatic logic [31:0] mk_tok(input int pid, input int addr, input int ep, input int maxl);
    return (32'((maxl + 2047) % 2048) << 21) | (32'(ep & 15) << 15) |
           (32'(addr & 127) << 8) | 32'(pid & 255);
  endfunction

  function automatic logic [31:0] mk_ctrl(input bit act, input bit ioc, input bit spd, input int err);
    return (32'(spd) << 29) | (32'(err & 3) << 27) | (32'(ioc) << 24) | (32'(act) << 23) | 32'h7FF;
  endfunction

  initial begin
    repeat (3) step(0, '0, '0, 0, 0);
    rst = 0;
    step(0, '0, '0, 0, 0);
    // R5 OUT success, length 8 of 8
    step(1, mk_ctrl(1, 1, 0, 3), mk_tok('hE1, 5, 2, 8), 0, 8);
    // R5 zero-length packet, maximum field all ones
    step(1, mk_ctrl(1, 0, 0, 3), mk_tok('h2D, 1, 0, 0), 0, 0);
    // R6 count one above maximum
    step(1, mk_ctrl(1, 0, 0, 3), mk_tok('h69, 9, 1, 64), 0, 65);
    // R7 short IN with detect enabled, then without
    step(1, mk_ctrl(1, 0, 1, 3), mk_tok('h69, 9, 1, 64), 0, 10);
    step(1, mk_ctrl(1, 0, 0, 3), mk_tok('h69, 9, 1, 64), 0, 10);
    // R8 timeout at each counter value
    for (int e = 0; e < 4; e++) step(1, mk_ctrl(1, 0, 0, e), mk_tok('hE1, 3, 3, 16), 3, 0);
    // R9 NAK, R10 stall, R11 babble
    step(1, mk_ctrl(1, 1, 0, 2), mk_tok('h69, 3, 3, 16), 1, 0);
    step(1, mk_ctrl(1, 0, 0, 2), mk_tok('h69, 3, 3, 16), 2, 0);
    step(1, mk_ctrl(1, 0, 0, 2), mk_tok('h69, 3, 3, 16), 4, 0);
    // R3 inactive with interrupt bit, R12 bad PID and reserved bit
    step(1, mk_ctrl(0, 1, 1, 1), mk_tok('h69, 7, 4, 8), 0, 8);
    step(1, mk_ctrl(1, 1, 0, 1), mk_tok('hA5, 7, 4, 8), 0, 8);
    step(1, mk_ctrl(1, 0, 0, 1), mk_tok('h69, 7, 4, 8) | 32'h0010_0000, 0, 8);
    step(0, '0, '0, 0, 0);
    // random mix, counts clustered around the maximum
    for (int i = 0; i < 4000; i++) begin
      int pk, ml, pid, n;
      logic [31:0] c;
      pk  = int'($urandom_range(0, 9));
      pid = (pk < 3) ? 'h69 : (pk < 6) ? 'hE1 : (pk < 8) ? 'h2D : int'($urandom_range(0, 255));
      ml  = ($urandom_range(0, 7) == 0) ? 0 : int'($urandom_range(0, 2047));
      n   = ml + int'($urandom_range(0, 4)) - 2;
      if (n < 0) n = 0;
      c = $urandom;
      if ($urandom_range(0, 4) != 0) c[23] = 1;
      step($urandom_range(0, 3) != 0, c,
           mk_tok(pid, int'($urandom_range(0, 127)), int'($urandom_range(0, 15)), ml) |
           (32'($urandom_range(0, 1)) << 19) | (($urandom_range(0, 15) == 0) ? 32'h0010_0000 : 32'h0),
           int'($urandom_range(0, 7)), n);
    end
    step(0, '0, '0, 0, 0);
    step(0, '0, '0, 0, 0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule